// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire bus whose target device has been left mid-byte and keeps the data line low. A request on `startReq` hands both lines to the sequencer. It first lets the data line go. Then, as long as the data line reads low, it clocks the bus one pulse at a time. Before each pulse it waits for the clock line to read high, so a target that stretches the clock is tolerated for a bounded number of checks. When the data line reads high, the sequencer drives a START and then a STOP, which returns every target's state machine to idle. It then reports the outcome with a one-cycle `done` and an `error` flag.

Both lines are open-drain with external pull-ups. The block only ever asserts a pull-low enable per line or releases it. It reads the true line level back through a two-stage synchronizer. Every wait is a whole number of time units. One unit is `TICK_CYCLES` system clocks, nominally 10 µs. A single down-counter times all waits. While idle, both pull-low enables are released, so an external mux can hand the lines back to the normal bus controller.

Top module: `i2c_bus_recovery`

## Requirements
- R1: While `busy` is low, both `sclDriveLow` and `sdaDriveLow` are 0. In the cycle after `done`, both are 0 again.
- R2: `startReq` is taken only while idle. `busy` rises in the cycle after acceptance and stays high through the single-cycle `done` pulse. A request made while busy has no effect, so no second busy period follows `done`.
- R3: If the data line already reads high when recovery starts, no recovery clock pulses are issued. The bus sees exactly one clock low phase, the one in the closing pattern, and `error` is 0 at `done`.
- R4: Each recovery clock pulse holds `sclDriveLow` at 1 for exactly `TICK_CYCLES` cycles and then releases the clock.
- R5: Pulses continue only while the data line reads low. Recovery fails with `error`=1 after exactly `MAX_PULSES` (default 9) pulses if the data line still reads low, and no START or STOP is driven in that case. A target that lets go on the last allowed pulse still gives success.
- R6: Before each pulse the clock line must read high. The block re-checks it once per time unit. After `STRETCH_CHECKS` (default 11) consecutive low readings, recovery ends with `error`=1 and no pulse is issued. A stretch shorter than that only delays recovery.
- R7: The closing pattern pulls the data line low while the clock is released (START). It then pulls the clock low, releases the clock, and releases the data line while the clock is released (STOP). Exactly one START and one STOP are driven on success.
- R8: The data line is released during the whole clocking phase. `sdaDriveLow` is asserted only inside the closing pattern.
- R9: `error` changes only when a recovery is accepted, where it clears, or in the cycle `done` rises, where it is set on failure. It holds its value while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request a recovery (taken only while idle) |
| busy | output | 1 | Recovery in progress, including the `done` cycle |
| done | output | 1 | One-cycle end-of-recovery pulse |
| error | output | 1 | Outcome of the last recovery: 1 means failure |
| sclIn | input | 1 | Clock line level read back from the pad |
| sdaIn | input | 1 | Data line level read back from the pad |
| sclDriveLow | output | 1 | Pull the clock line low (0 releases it) |
| sdaDriveLow | output | 1 | Pull the data line low (0 releases it) |

## Verification
The bench runs the recovery against a modelled target that holds the data line until it has seen a chosen number of rising clock edges. A target that never holds checks the no-pulse path. Release after three pulses checks normal clocking and pulse width. Release on exactly the ninth pulse and a target that never releases separate the last successful pulse from the pulse-limit failure. A clock line held low briefly and a clock line held low permanently separate tolerated stretching from the stretch-limit failure. A repeated request during a run shows that requests made while busy are dropped.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CHK_SDA,
    ST_CHK_SCL,
    ST_STR_WAIT,
    ST_PLOW,
    ST_PHIGH,
    ST_CL_START,
    ST_CL_SCLLO,
    ST_CL_SCLHI,
    ST_CL_STOP,
    ST_FIN
  } recState_t;

  typedef struct packed {
    logic loadTick;
    logic clrPulse;
    logic incPulse;
    logic clrStretch;
    logic incStretch;
  } ctrlStrobe_t;

  typedef struct packed {
    logic tickDone;
    logic pulseAtMax;
    logic stretchAtMax;
  } dpStatus_t;

endpackage

// File: rtl/busrec_sync.sv
module busrec_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] asyncIn,
  output logic [LINES-1:0] syncOut
);

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], asyncIn[g]};
    end
    assign syncOut[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/busrec_datapath.sv
module busrec_datapath
  import busrec_pkg::*;
#(
  parameter int TICK_CYCLES    = 500,
  parameter int MAX_PULSES     = 9,
  parameter int STRETCH_CHECKS = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam int SW = $clog2(STRETCH_CHECKS + 1);
  localparam logic [TW-1:0] TICK_RELOAD = TW'(TICK_CYCLES - 1);
  localparam logic [PW-1:0] PULSE_LIMIT = PW'(MAX_PULSES);
  localparam logic [SW-1:0] STR_LAST    = SW'(STRETCH_CHECKS - 1);

  logic [TW-1:0] tickCnt;
  logic [PW-1:0] pulseCnt;
  logic [SW-1:0] stretchCnt;

  // shared time-unit down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tickCnt <= '0;
    else if (strobe.loadTick) tickCnt <= TICK_RELOAD;
    else if (tickCnt != '0)   tickCnt <= tickCnt - 1'b1;
  end

  // recovery pulses issued so far
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          pulseCnt <= '0;
    else if (strobe.clrPulse)                           pulseCnt <= '0;
    else if (strobe.incPulse && pulseCnt != PULSE_LIMIT) pulseCnt <= pulseCnt + 1'b1;
  end

  // consecutive low readings of the clock line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                           stretchCnt <= '0;
    else if (strobe.clrStretch)                          stretchCnt <= '0;
    else if (strobe.incStretch && stretchCnt != STR_LAST) stretchCnt <= stretchCnt + 1'b1;
  end

  always_comb begin
    status.tickDone     = (tickCnt == '0);
    status.pulseAtMax   = (pulseCnt == PULSE_LIMIT);
    status.stretchAtMax = (stretchCnt == STR_LAST);
  end

endmodule

// File: rtl/busrec_ctrl.sv
module busrec_ctrl
  import busrec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        sclHigh,
  input  logic        sdaHigh,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic        sclDriveLow,
  output logic        sdaDriveLow
);

  recState_t state, stateNext;
  logic failNext;
  logic errFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    failNext  = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        stateNext         = ST_SETTLE;
        strobe.loadTick   = 1'b1;
        strobe.clrPulse   = 1'b1;
        strobe.clrStretch = 1'b1;
      end
      ST_SETTLE: if (status.tickDone) stateNext = ST_CHK_SDA;
      ST_CHK_SDA: begin
        if (sdaHigh) begin
          stateNext       = ST_CL_START;
          strobe.loadTick = 1'b1;
        end else if (status.pulseAtMax) begin
          stateNext = ST_FIN;
          failNext  = 1'b1;
        end else begin
          stateNext = ST_CHK_SCL;
        end
      end
      ST_CHK_SCL: begin
        if (sclHigh) begin
          stateNext         = ST_PLOW;
          strobe.loadTick   = 1'b1;
          strobe.clrStretch = 1'b1;
        end else if (status.stretchAtMax) begin
          stateNext = ST_FIN;
          failNext  = 1'b1;
        end else begin
          stateNext         = ST_STR_WAIT;
          strobe.loadTick   = 1'b1;
          strobe.incStretch = 1'b1;
        end
      end
      ST_STR_WAIT: if (status.tickDone) stateNext = ST_CHK_SCL;
      ST_PLOW: if (status.tickDone) begin
        stateNext       = ST_PHIGH;
        strobe.loadTick = 1'b1;
      end
      ST_PHIGH: if (status.tickDone) begin
        stateNext       = ST_CHK_SDA;
        strobe.incPulse = 1'b1;
      end
      ST_CL_START: if (status.tickDone) begin
        stateNext       = ST_CL_SCLLO;
        strobe.loadTick = 1'b1;
      end
      ST_CL_SCLLO: if (status.tickDone) begin
        stateNext       = ST_CL_SCLHI;
        strobe.loadTick = 1'b1;
      end
      ST_CL_SCLHI: if (status.tickDone) begin
        stateNext       = ST_CL_STOP;
        strobe.loadTick = 1'b1;
      end
      ST_CL_STOP: if (status.tickDone) stateNext = ST_FIN;
      ST_FIN: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   errFlag <= 1'b0;
    else if (state == ST_IDLE && startReq)       errFlag <= 1'b0;
    else if (state != ST_FIN && stateNext == ST_FIN) errFlag <= failNext;
  end

  always_comb begin
    busy        = (state != ST_IDLE);
    done        = (state == ST_FIN);
    error       = errFlag;
    sclDriveLow = (state == ST_PLOW) || (state == ST_CL_SCLLO);
    sdaDriveLow = (state == ST_CL_START) || (state == ST_CL_SCLLO) ||
                  (state == ST_CL_SCLHI);
  end

endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery
  import busrec_pkg::*;
#(
  parameter int TICK_CYCLES    = 500,
  parameter int MAX_PULSES     = 9,
  parameter int STRETCH_CHECKS = 11,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  output logic busy,
  output logic done,
  output logic error,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclDriveLow,
  output logic sdaDriveLow
);

  logic [1:0]  lineSync;
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  busrec_sync #(.LINES(2), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({sclIn, sdaIn}),
    .syncOut (lineSync)
  );

  busrec_datapath #(
    .TICK_CYCLES   (TICK_CYCLES),
    .MAX_PULSES    (MAX_PULSES),
    .STRETCH_CHECKS(STRETCH_CHECKS)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .status (status)
  );

  busrec_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .sclHigh     (lineSync[1]),
    .sdaHigh     (lineSync[0]),
    .status      (status),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow)
  );

endmodule

// File: rtl/busrec_checker.sv
module busrec_checker (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic busy,
  input logic done,
  input logic error,
  input logic sclDriveLow,
  input logic sdaDriveLow
);

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDriveLow && !sdaDriveLow));

  // R2
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);

  // R7
  start_clk_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclDriveLow);

  // R7
  stop_clk_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDriveLow) |-> !sclDriveLow);

  // R9
  error_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> done);

  // R9
  error_hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startReq && !$past(busy)) |=> $stable(error));

endmodule

bind i2c_bus_recovery busrec_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .startReq    (startReq),
  .busy        (busy),
  .done        (done),
  .error       (error),
  .sclDriveLow (sclDriveLow),
  .sdaDriveLow (sdaDriveLow)
);

// File: tb/sim_i2c_bus_recovery.sv
module sim_i2c_bus_recovery;

  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 20;
  localparam int PULSES     = 9;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic busy, done, error, sclDriveLow, sdaDriveLow;

  logic sclHold = 1'b0;
  int   releaseAfter = 0;
  int   sclRises, sclFalls, startsSeen, stopsSeen, lastLowWidth, lowRun;
  logic prevScl, prevSdaDrv;
  int   total = 0;
  int   bad = 0;
  int   cycles = 0;

  wire sclLine = !(sclDriveLow || sclHold);
  wire sdaLine = !(sdaDriveLow || (sclRises < releaseAfter));

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_recovery #(.TICK_CYCLES(TICK), .MAX_PULSES(PULSES)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .busy(busy), .done(done), .error(error),
    .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

  // bus monitor, sampled on the falling edge
  always @(negedge clk) begin
    cycles++;
    if (prevScl && !sclLine) sclFalls++;
    if (!prevScl && sclLine) sclRises++;
    if (!prevSdaDrv && sdaDriveLow && sclLine) startsSeen++;
    if (prevSdaDrv && !sdaDriveLow && sclLine) stopsSeen++;
    if (sclDriveLow) lowRun++;
    else if (lowRun != 0) begin lastLowWidth = lowRun; lowRun = 0; end
    prevScl    = sclLine;
    prevSdaDrv = sdaDriveLow;
    if (cycles > WATCHDOG) begin
      bad++; total++;
      $display("FAIL watchdog: actual cycles=%0d expected <= %0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    sclRises = 0; sclFalls = 0; startsSeen = 0; stopsSeen = 0;
    lastLowWidth = 0; lowRun = 0;
  endtask

  // runs one recovery; returns error at done
  task automatic runRecovery(input int sclReleaseAt, input int extraStartAt,
                             output int errOut, output int firstLow);
    int cyc = 0;
    firstLow = 0;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    while (!done && cyc < 200 * TICK) begin
      @(negedge clk);
      cyc++;
      if (cyc == sclReleaseAt) sclHold = 1'b0;
      startReq = (cyc == extraStartAt);
      if (firstLow == 0 && lastLowWidth != 0) firstLow = lastLowWidth;
      if (!busy) check(1'b0, "R2 busy dropped early", busy, 1);
    end
    startReq = 1'b0;
    check(done == 1'b1, "R2 done reached", done, 1);
    errOut = error;
    @(negedge clk);
    check(!done && !busy, "R2 done single cycle", {done, busy}, 0);
    check(!sclDriveLow && !sdaDriveLow, "R1 released after done",
          {sclDriveLow, sdaDriveLow}, 0);
  endtask

  task automatic testNoStuck();
    int e, w;
    releaseAfter = 0; clearMon();
    runRecovery(-1, -1, e, w);
    check(sclFalls == 1, "R3 only closing clock low", sclFalls, 1);
    check(e == 0, "R3 success", e, 0);
    check(startsSeen == 1 && stopsSeen == 1, "R7 one START one STOP",
          startsSeen * 10 + stopsSeen, 11);
  endtask

  task automatic testReleaseAfter(input int n, input int extra);
    int e, w;
    releaseAfter = n; clearMon();
    runRecovery(-1, extra, e, w);
    check(sclFalls == n + 1, "R5 pulses then closing", sclFalls, n + 1);
    check(e == 0, "R5 success on release", e, 0);
    check(w == TICK, "R4 pulse low width", w, TICK);
    check(startsSeen == 1 && stopsSeen == 1, "R7 closing pattern",
          startsSeen * 10 + stopsSeen, 11);
  endtask

  task automatic testNeverRelease();
    int e, w;
    releaseAfter = 1000; clearMon();
    runRecovery(-1, -1, e, w);
    check(sclFalls == PULSES, "R5 pulse limit", sclFalls, PULSES);
    check(e == 1, "R5 error on limit", e, 1);
    check(startsSeen == 0 && stopsSeen == 0, "R5 no START/STOP on failure",
          startsSeen + stopsSeen, 0);
    repeat (5) @(negedge clk);
    check(error == 1, "R9 error held while idle", error, 1);
    releaseAfter = 0;
  endtask

  task automatic testStretchShort();
    int e, w;
    sclHold = 1'b1;
    @(negedge clk);
    releaseAfter = 1; clearMon();
    runRecovery(5 * TICK, -1, e, w);
    check(e == 0, "R6 short stretch tolerated", e, 0);
    check(sclFalls == 2, "R6 one pulse after stretch", sclFalls, 2);
  endtask

  task automatic testStretchStuck();
    int e, w;
    sclHold = 1'b1;
    @(negedge clk);
    releaseAfter = 1; clearMon();
    runRecovery(-1, -1, e, w);
    check(e == 1, "R6 stretch limit error", e, 1);
    check(sclFalls == 0, "R6 no pulse while clock held", sclFalls, 0);
    check(startsSeen == 0, "R8 data line untouched", startsSeen, 0);
    sclHold = 1'b0;
    releaseAfter = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testBusyIgnore();
    releaseAfter = 2;
    testReleaseAfter(2, 3 * TICK);
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R2 request during busy ignored", busy, 0);
  endtask

  initial begin
    prevScl = 1'b1; prevSdaDrv = 1'b0;
    clearMon();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !error, "R1 reset state busy/done/error",
          {busy, done, error}, 0);
    check(!sclDriveLow && !sdaDriveLow, "R1 reset lines released",
          {sclDriveLow, sdaDriveLow}, 0);
    testNoStuck();
    testReleaseAfter(3, -1);
    testReleaseAfter(PULSES, -1);
    testNeverRelease();
    testNoStuck();           // R9: error cleared by new run
    testStretchShort();
    testStretchStuck();
    testBusyIgnore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule